// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Input Capture

This block is a down-counting timer with two companion registers, A and B, and two input pins. A three-bit mode field in a control register picks one of three behaviours. In pulse-width mode the counter runs on every clock and, on reaching zero, reloads alternately from A and then B, optionally toggling an output pin at each reload. In event-counter mode the counter steps down once per rising edge on pin A. In capture mode the counter free-runs, and A and B take a snapshot of it on a chosen edge of their own pins.

Software reaches the block through a small word-wide register port with one address for the counter, A, B and the control word. The control word holds the mode, a run bit that doubles as the underflow flag in capture mode, and a pending and an enable flag for each of the A and B sources. Two interrupt lines, one per source, leave the block. Both pins pass through a two-flop synchroniser before any edge is detected. In capture mode, underflow and capture A share interrupt line A, so software reads both the pending flag and the underflow flag to tell which one fired.

Top module: `tri_mode_timer`

## Requirements
- R1: After reset the counter, A, B and the control word read as zero, and pin_a_o, irq_a and irq_b are 0.
- R2: Address 0 is the counter, 1 is register A, 2 is register B and 3 is the control word. rdata shows the addressed register in the same cycle, and writes take effect at the next clock edge. Control bit layout: [0] run/underflow flag, [3:1] mode {m2,m1,m0}, [4] pending A, [5] enable A, [6] pending B, [7] enable B. Bits above 7 read as 0.
- R3: Modes 100 and 101 are pulse-width modes. While bit 0 is 1, the counter decrements every clock. A step from 0 reloads it instead of wrapping, first from A after the run bit is set, then from B, alternating. The gap between reloads is the loaded value plus one clock. A reload from A sets pending A and a reload from B sets pending B.
- R4: In mode 101 pin_a_o inverts at every reload. In every other mode pin_a_o holds its value.
- R5: In pulse-width and event-counter modes, clearing bit 0 freezes the counter.
- R6: Modes 000 and 001 count events. While bit 0 is 1, each synchronised rising edge on pin A decrements the counter. A step from 0 wraps to all ones and sets pending A.
- R7: In event-counter mode a rising edge on pin B sets pending B, whether or not the counter runs.
- R8: Modes with m1 = 1 are capture modes. The counter decrements every clock whatever bit 0 holds, and a step from 0 wraps to all ones and sets bit 0.
- R9: In capture mode, m0 chooses the edge on pin A and m2 the edge on pin B (0 = rising, 1 = falling). The chosen edge copies the counter into A (or B) and sets pending A (or B); the other edge copies nothing and sets no flag. The copied value is the counter value readable in the cycle the pin changed, minus 2.
- R10: irq_a is 1 when enable A is 1 and either pending A is 1 or (capture mode and bit 0 is 1). irq_b is 1 when enable B and pending B are both 1.
- R11: Pending flags, and bit 0 in capture mode, stay set until software writes 0 to them. When a hardware set and a software clear fall in the same cycle, the flag ends up set.
- R12: A software write to the counter overrides a decrement or reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register select for both read and write |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data of the addressed register |
| pin_a_i | input | 1 | Pin A input (event clock, capture trigger A) |
| pin_b_i | input | 1 | Pin B input (event B, capture trigger B) |
| pin_a_o | output | 1 | Pin A output, toggled at reloads in mode 101 |
| irq_a | output | 1 | Interrupt line for source A |
| irq_b | output | 1 | Interrupt line for source B |

## Verification
The bench builds the timer with CNT_W = 8 and SYNC_STAGES = 2. An 8-bit counter makes the wrap from 0 to 0xFF in event and capture modes reachable in a few clocks. It also lets the sweeps cover every pulse-width combination of A and B from 0 to 3 in both toggle settings, every start value 0..3 against 0..5 pin-A pulses in both event modes, and all four capture edge polarities. The two-stage synchroniser fixes the capture offset at 2, so each expected snapshot is computed from a counter read taken when the pin is driven.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTL_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_COUNT = 2'd0,
        ADR_REG_A = 2'd1,
        ADR_REG_B = 2'd2,
        ADR_CTRL  = 2'd3
    } tmr_addr_e;

    // Control word, most significant field first (bit 7 .. bit 0).
    typedef struct packed {
        logic       en_b;
        logic       pend_b;
        logic       en_a;
        logic       pend_a;
        logic [2:0] mode;   // {m2, m1, m0}
        logic       c0;     // run bit, or underflow flag in capture
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        OP_PWM     = 2'd0,
        OP_EVENT   = 2'd1,
        OP_CAPTURE = 2'd2
    } tmr_op_e;

    localparam logic [2:0] MODE_PWM_TOGGLE = 3'b101;

    function automatic tmr_op_e decode_op(input logic [2:0] mode);
        if (mode[1])      return OP_CAPTURE;
        else if (mode[2]) return OP_PWM;
        else              return OP_EVENT;
    endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // STAGES synchroniser flops plus one flop holding the previous level
    localparam int LAST = STAGES;

    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LAST-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[LAST-1] & ~sh_q[LAST];
    assign fall = ~sh_q[LAST-1] & sh_q[LAST];

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_val,
    input  logic         dec,
    input  logic         reload_en,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (sw_wr) begin
            cnt_d = sw_val;
        end else if (dec) begin
            if (cnt_q == '0) begin
                wrap  = 1'b1;
                cnt_d = reload_en ? reload_val : cnt_q - 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/tri_mode_timer.sv
module tri_mode_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              pin_a_i,
    input  logic              pin_b_i,
    output logic              pin_a_o,
    output logic              irq_a,
    output logic              irq_b
);
    localparam int NPINS = 2;

    typedef struct packed {
        logic [CNT_W-1:0] reg_a;
        logic [CNT_W-1:0] reg_b;
        tmr_ctrl_t        ctl;
        logic             next_b;
        logic             pin_out;
    } state_t;

    state_t st_d, st_q;
    tmr_ctrl_t ctl_q;

    logic [NPINS-1:0] pin_raw, pin_rise, pin_fall;

    tmr_op_e          op;
    logic             wr_cnt, wr_a, wr_b, wr_ctl;
    logic             dec, reload_en, reload_fire;
    logic [CNT_W-1:0] reload_val, cnt_q;
    logic             cnt_wrap;
    logic             edge_a, edge_b;
    logic             set_pa, set_pb, set_c0;

    assign ctl_q   = st_q.ctl;
    assign pin_raw = {pin_b_i, pin_a_i};

    for (genvar p = 0; p < NPINS; p++) begin : g_sync
        tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_raw[p]),
            .rise (pin_rise[p]),
            .fall (pin_fall[p])
        );
    end

    // Decode and event sources
    always_comb begin
        op     = decode_op(ctl_q.mode);
        wr_cnt = wr_en && (addr == ADR_COUNT);
        wr_a   = wr_en && (addr == ADR_REG_A);
        wr_b   = wr_en && (addr == ADR_REG_B);
        wr_ctl = wr_en && (addr == ADR_CTRL);

        edge_a = ctl_q.mode[0] ? pin_fall[0] : pin_rise[0];
        edge_b = ctl_q.mode[2] ? pin_fall[1] : pin_rise[1];

        reload_val = st_q.next_b ? st_q.reg_b : st_q.reg_a;

        unique case (op)
            OP_PWM: begin
                dec       = ctl_q.c0;
                reload_en = 1'b1;
            end
            OP_EVENT: begin
                dec       = ctl_q.c0 & pin_rise[0];
                reload_en = 1'b0;
            end
            OP_CAPTURE: begin
                dec       = 1'b1;
                reload_en = 1'b0;
            end
            default: begin
                dec       = 1'b0;
                reload_en = 1'b0;
            end
        endcase
    end

    tmr_down_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wr     (wr_cnt),
        .sw_val    (wdata),
        .dec       (dec),
        .reload_en (reload_en),
        .reload_val(reload_val),
        .count     (cnt_q),
        .wrap      (cnt_wrap)
    );

    // Flag sources per mode
    always_comb begin
        reload_fire = (op == OP_PWM) && cnt_wrap;
        set_pa = 1'b0;
        set_pb = 1'b0;
        set_c0 = 1'b0;
        unique case (op)
            OP_PWM: begin
                set_pa = reload_fire & ~st_q.next_b;
                set_pb = reload_fire &  st_q.next_b;
            end
            OP_EVENT: begin
                set_pa = cnt_wrap;
                set_pb = pin_rise[1];
            end
            OP_CAPTURE: begin
                set_pa = edge_a;
                set_pb = edge_b;
                set_c0 = cnt_wrap;
            end
            default: ;
        endcase
    end

    // Next state
    always_comb begin
        st_d = st_q;

        if (wr_ctl) st_d.ctl = tmr_ctrl_t'(wdata[CTL_W-1:0]);
        // hardware set beats a same-cycle software clear
        st_d.ctl.pend_a = st_d.ctl.pend_a | set_pa;
        st_d.ctl.pend_b = st_d.ctl.pend_b | set_pb;
        st_d.ctl.c0     = st_d.ctl.c0     | set_c0;

        if (op == OP_CAPTURE && edge_a) st_d.reg_a = cnt_q;
        else if (wr_a)                  st_d.reg_a = wdata;

        if (op == OP_CAPTURE && edge_b) st_d.reg_b = cnt_q;
        else if (wr_b)                  st_d.reg_b = wdata;

        if (op != OP_PWM || !ctl_q.c0) st_d.next_b = 1'b0;
        else if (reload_fire)          st_d.next_b = ~st_q.next_b;

        if (reload_fire && ctl_q.mode == MODE_PWM_TOGGLE)
            st_d.pin_out = ~st_q.pin_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read path and outputs
    always_comb begin
        unique case (tmr_addr_e'(addr))
            ADR_COUNT: rdata = cnt_q;
            ADR_REG_A: rdata = st_q.reg_a;
            ADR_REG_B: rdata = st_q.reg_b;
            ADR_CTRL:  rdata = CNT_W'(ctl_q);
            default:   rdata = '0;
        endcase
    end

    assign pin_a_o = st_q.pin_out;
    assign irq_a   = ctl_q.en_a & (ctl_q.pend_a | ((op == OP_CAPTURE) & ctl_q.c0));
    assign irq_b   = ctl_q.en_b & ctl_q.pend_b;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [CNT_W-1:0] cnt,
    input tmr_ctrl_t        ctl,
    input logic             pin_a_o,
    input logic             irq_a,
    input logic             irq_b
);
    logic cnt_wr, ctl_wr;
    assign cnt_wr = wr_en && (addr == 2'd0);
    assign ctl_wr = wr_en && (addr == 2'd3);

    // R11
    pend_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.pend_a && !ctl_wr) |=> ctl.pend_a);

    // R11
    pend_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.pend_b && !ctl_wr) |=> ctl.pend_b);

    // R8
    cap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode[1] && !cnt_wr) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

    // R8
    cap_wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode[1] && cnt == '0 && !cnt_wr) |=> ctl.c0);

    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.mode[1] && !ctl.c0 && !cnt_wr) |=> $stable(cnt));

    // R4
    pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode != 3'b101) |=> $stable(pin_a_o));

    // R3
    pwm_reload_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode[2:1] == 2'b10 && ctl.c0 && cnt == '0 && !cnt_wr)
            |=> (ctl.pend_a || ctl.pend_b));

    // R10
    irq_a_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.en_a && ctl.pend_a) |-> irq_a);

    // R10
    irq_b_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.en_b |-> !irq_b);

endmodule

bind tri_mode_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .cnt    (cnt_q),
    .ctl    (ctl_q),
    .pin_a_o(pin_a_o),
    .irq_a  (irq_a),
    .irq_b  (irq_b)
);

// File: tb/tb_tri_mode_timer.sv
module tb_tri_mode_timer;
    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         pin_a = 1'b0;
    logic         pin_b = 1'b0;
    logic         pin_a_o, irq_a, irq_b;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tri_mode_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_a_i(pin_a), .pin_b_i(pin_b), .pin_a_o(pin_a_o),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; addr = a; wdata = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    function automatic int mk_ctl(input int enb, input int pb, input int ena,
                                  input int pa, input int mode, input int c0);
        return (enb << 7) | (pb << 6) | (ena << 5) | (pa << 4) | (mode << 1) | c0;
    endfunction

    int v, v0, prev, cyc, nchg, keep;

    initial begin
        tick(3);
        // R1: state while in reset and just after release
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg after reset", v, 0);
        end
        chk("R1 pin_a_o", int'(pin_a_o), 0);
        chk("R1 irq_a", int'(irq_a), 0);
        chk("R1 irq_b", int'(irq_b), 0);
        tick(1);
        rst_n = 1'b1;
        tick(1);

        // R2: write/read map, upper bits of the control word
        wr(2'd1, 8'h5A); wr(2'd2, 8'hC3); wr(2'd0, 8'h37);
        wr(2'd3, mk_ctl(1, 1, 1, 1, 0, 0));
        rd(2'd1, v); chk("R2 reg A readback", v, 8'h5A);
        rd(2'd2, v); chk("R2 reg B readback", v, 8'hC3);
        rd(2'd0, v); chk("R2 count readback", v, 8'h37);
        rd(2'd3, v); chk("R2 ctrl readback", v, 8'hF0);
        // R10: both sources flagged and enabled
        chk("R10 irq_a pend+en", int'(irq_a), 1);
        chk("R10 irq_b pend+en", int'(irq_b), 1);
        wr(2'd3, mk_ctl(0, 1, 0, 1, 0, 0));
        chk("R10 irq_a disabled", int'(irq_a), 0);
        chk("R10 irq_b disabled", int'(irq_b), 0);
        wr(2'd3, mk_ctl(1, 0, 1, 0, 0, 0));
        chk("R11 clear pend A by write", int'(irq_a), 0);
        chk("R11 clear pend B by write", int'(irq_b), 0);

        // R5: stopped in pulse-width and event modes
        wr(2'd0, 8'h21); wr(2'd3, mk_ctl(0, 0, 0, 0, 3'b101, 0));
        tick(8);
        rd(2'd0, v); chk("R5 pwm stopped", v, 8'h21);
        wr(2'd3, mk_ctl(0, 0, 0, 0, 3'b000, 0));
        for (int k = 0; k < 3; k++) begin
            pin_a = 1'b1; tick(3); pin_a = 1'b0; tick(3);
        end
        rd(2'd0, v); chk("R5 event stopped", v, 8'h21);

        // R7: pin B edge in event mode, counter stopped
        wr(2'd3, mk_ctl(1, 0, 0, 0, 3'b000, 0));
        pin_b = 1'b1; tick(4);
        rd(2'd3, v); chk("R7 pend B on pin B rise", (v >> 6) & 1, 1);
        chk("R10 irq_b from event", int'(irq_b), 1);
        pin_b = 1'b0; tick(4);

        // R3/R4: pulse-width sweep
        for (int tg = 0; tg < 2; tg++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    wr(2'd3, 0);
                    wr(2'd0, 0); wr(2'd1, a); wr(2'd2, b);
                    wr(2'd3, mk_ctl(0, 0, 0, 0, tg ? 3'b101 : 3'b100, 1));
                    addr = 2'd3;
                    prev = int'(pin_a_o); cyc = 0; nchg = 0;
                    if (tg == 1) begin
                        for (int i = 0; i < 40 && nchg < 5; i++) begin
                            @(negedge clk);
                            cyc++;
                            if (int'(pin_a_o) != prev) begin
                                prev = int'(pin_a_o);
                                if (nchg == 0) begin
                                    chk("R3 first reload sets pend A", (int'(rdata) >> 4) & 1, 1);
                                    chk("R3 first reload leaves pend B", (int'(rdata) >> 6) & 1, 0);
                                end else begin
                                    chk("R3 reload gap", cyc, (nchg % 2 == 1) ? a + 1 : b + 1);
                                end
                                nchg++;
                                cyc = 0;
                            end
                        end
                        chk("R4 toggles seen", nchg, 5);
                    end else begin
                        keep = int'(pin_a_o);
                        tick(20);
                        chk("R4 no toggle in mode 100", int'(pin_a_o), keep);
                        chk("R3 pend A set", (int'(rdata) >> 4) & 1, 1);
                        chk("R3 pend B set", (int'(rdata) >> 6) & 1, 1);
                    end
                end
            end
        end

        // R12: software write to counter wins over decrement
        wr(2'd3, mk_ctl(0, 0, 0, 0, 3'b010, 0));
        wr(2'd0, 8'h50);
        rd(2'd0, v); chk("R12 write wins", v, 8'h50);
        tick(1);
        rd(2'd0, v); chk("R8 free-run step", v, 8'h4F);

        // R6: event-count sweep
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n < 4; n++) begin
                for (int k = 0; k < 6; k++) begin
                    wr(2'd3, 0);
                    wr(2'd0, n);
                    wr(2'd3, mk_ctl(0, 0, 0, 0, m, 1));
                    for (int p = 0; p < k; p++) begin
                        pin_a = 1'b1; tick(3); pin_a = 1'b0; tick(3);
                    end
                    tick(3);
                    rd(2'd0, v); chk("R6 event count", v, (n - k) & MASK);
                    rd(2'd3, v); chk("R6 underflow pend A", (v >> 4) & 1, (k > n) ? 1 : 0);
                end
            end
        end

        // R9: capture with each edge polarity pair
        for (int pa = 0; pa < 2; pa++) begin
            for (int pb = 0; pb < 2; pb++) begin
                pin_a = 1'(pa); pin_b = 1'(pb);
                tick(5);
                wr(2'd3, mk_ctl(1, 0, 1, 0, (pb << 2) | 2 | pa, 0));
                wr(2'd0, 8'h80);
                rd(2'd0, v0);
                pin_a = ~1'(pa);
                tick(6);
                rd(2'd1, v); chk("R9 capture A value", v, (v0 - 2) & MASK);
                rd(2'd3, v); chk("R9 pend A on capture", (v >> 4) & 1, 1);
                chk("R10 irq_a on capture", int'(irq_a), 1);
                wr(2'd3, mk_ctl(1, 0, 1, 0, (pb << 2) | 2 | pa, 0));
                rd(2'd1, keep);
                pin_a = 1'(pa);
                tick(6);
                rd(2'd1, v); chk("R9 other edge A no capture", v, keep);
                rd(2'd3, v); chk("R9 other edge A no pend", (v >> 4) & 1, 0);

                rd(2'd0, v0);
                pin_b = ~1'(pb);
                tick(6);
                rd(2'd2, v); chk("R9 capture B value", v, (v0 - 2) & MASK);
                rd(2'd3, v); chk("R9 pend B on capture", (v >> 6) & 1, 1);
                chk("R10 irq_b on capture", int'(irq_b), 1);
                wr(2'd3, mk_ctl(1, 0, 1, 0, (pb << 2) | 2 | pa, 0));
                rd(2'd2, keep);
                pin_b = 1'(pb);
                tick(6);
                rd(2'd2, v); chk("R9 other edge B no capture", v, keep);
                rd(2'd3, v); chk("R9 other edge B no pend", (v >> 6) & 1, 0);
            end
        end
        pin_a = 1'b0; pin_b = 1'b0;
        tick(5);

        // R8/R10: capture underflow sets bit 0 and raises irq_a
        wr(2'd3, mk_ctl(0, 0, 1, 0, 3'b010, 0));
        wr(2'd0, 3);
        wr(2'd3, mk_ctl(0, 0, 1, 0, 3'b010, 0));
        tick(4);
        rd(2'd0, v); chk("R8 wrap value", v, 8'hFE);
        rd(2'd3, v); chk("R8 underflow flag", v & 1, 1);
        chk("R10 irq_a from underflow", int'(irq_a), 1);

        // R11: set wins over same-cycle clear, then a lone clear works
        wr(2'd0, 1);
        wr(2'd3, mk_ctl(0, 0, 0, 0, 3'b010, 0));
        wr(2'd3, mk_ctl(0, 0, 0, 0, 3'b010, 0));
        rd(2'd3, v); chk("R11 set beats clear", v & 1, 1);
        wr(2'd3, mk_ctl(0, 0, 0, 0, 3'b010, 0));
        rd(2'd3, v); chk("R11 clear alone", v & 1, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule